// File: doc/BRIEF.md
# Counter Polling Bus Arbiter

This block decides which of several bus masters may use a shared bus. Every master that wants the bus raises its request bit; the OR of these bits forms one shared request line. While that line is high and nobody owns the bus, the arbiter steps an index counter. The counter value goes out to all masters on a narrow index bus.

When the counter lands on a master that is requesting, that master is treated as reporting busy. The counter stops there, and on the next clock that master is granted the bus. It keeps the bus for as long as it holds its request. When it drops the request, the bus is freed.

A one-bit mode input controls where polling begins again after a release. In fixed mode polling restarts at device 0, so a lower index always wins. In rotating mode polling restarts at the device after the last owner, so every device gets an equal share. The grant vector is a one-hot drive enable, so at most one master ever drives the shared bus.

Top module: `poll_arbiter`

## Requirements
- R1: `reqLine` is the OR of all `devReq` bits in the same cycle.
- R2: While the bus is unowned, `reqLine` is high and the device addressed by `pollIdx` is not requesting, `pollIdx` rises by one on each clock edge. It wraps from NUM_DEV-1 to 0.
- R3: If the bus is unowned and `devReq[pollIdx]` is high at a clock edge, then after that edge `busBusy` is 1 and `pollIdx` keeps its value. Both stay that way as long as that device keeps its request.
- R4: `busGrant` has at most one bit set. Bit i is set exactly when `busBusy` is 1 and `pollIdx` equals i.
- R5: When the owner drops its request, the next clock edge clears `busBusy` and `busGrant`. At that edge `pollIdx` becomes 0 in fixed mode, or the owner's index plus one (wrapping) in rotating mode.
- R6: Fixed mode is selected by `rotateMode` = 0. In fixed mode, among devices requesting at the same time, the lowest index wins once polling has restarted from 0.
- R7: Rotating mode is selected by `rotateMode` = 1. In rotating mode, if all devices keep requesting, ownership passes through the indices in increasing order with wraparound.
- R8: If the bus is unowned and no device is requesting, `pollIdx` holds its value and no grant is active.
- R9: `rotateMode` is sampled only on clock edges where the bus is unowned. A change made while the bus is owned does not affect the restart point of that ownership's release.
- R10: After reset, `pollIdx` is 0, `busBusy` is 0, `busGrant` is all zero, and fixed mode is in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rotateMode | input | 1 | 0 = restart polling at device 0; 1 = restart after the last owner |
| devReq | input | NUM_DEV | Per-device bus request, held for as long as the device owns the bus |
| reqLine | output | 1 | Shared request line (OR of all requests) |
| pollIdx | output | IDX_W | Polling counter value broadcast to all devices |
| busBusy | output | 1 | Bus is owned by the device at `pollIdx` |
| busGrant | output | NUM_DEV | One-hot drive enable for the owning device |

## Verification
A counter that stepped when it should not, or at the wrong moment, would show on `pollIdx` in the very next cycle. It would also change which device wins, so the grant vector would point at the wrong device within at most NUM_DEV cycles. A mode latch that tracked `rotateMode` while the bus was owned would show only at the release edge, as a wrong restart index on `pollIdx`. A stuck ownership flag would show as `busBusy` failing to fall one cycle after the owner's request drops. For these reasons the bench compares every port against a behavioural model on every cycle. Separate targeted checks cover the cycle counts to a grant, the winner order and the restart points.

// File: rtl/pollarb_pkg.sv
package pollarb_pkg;

  typedef enum logic {
    ST_POLL = 1'b0,
    ST_OWN  = 1'b1
  } arbState_e;

  typedef struct packed {
    logic stepIdx;
    logic seize;
    logic freeBus;
  } ctlStrobe_t;

endpackage

// File: rtl/pollarb_match.sv
module pollarb_match #(
  parameter int NUM_DEV = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_DEV-1:0] devReq,
  input  logic [IDX_W-1:0]   pollIdx,
  input  logic               owned,
  output logic               anyReq,
  output logic               hitReq,
  output logic [NUM_DEV-1:0] grantVec
);

  logic [NUM_DEV-1:0] selVec;
  logic [NUM_DEV-1:0] hitVec;

  // one comparator per device: the device-side "my index is on the lines"
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign selVec[g] = (pollIdx == IDX_W'(g));
    assign hitVec[g] = selVec[g] & devReq[g];
  end

  assign anyReq   = |devReq;
  assign hitReq   = |hitVec;
  assign grantVec = owned ? selVec : '0;

endmodule

// File: rtl/pollarb_ctrl.sv
module pollarb_ctrl
  import pollarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyReq,
  input  logic       hitReq,
  output ctlStrobe_t strobe,
  output logic       owned
);

  arbState_e stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_POLL: begin
        if (anyReq) begin
          if (hitReq) begin
            strobe.seize = 1'b1;
            stateD       = ST_OWN;
          end else begin
            strobe.stepIdx = 1'b1;
          end
        end
      end
      ST_OWN: begin
        if (!hitReq) begin
          strobe.freeBus = 1'b1;
          stateD         = ST_POLL;
        end
      end
      default: stateD = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_POLL;
    else        stateQ <= stateD;
  end

  assign owned = (stateQ == ST_OWN);

  // R5: owner dropping its request frees the bus on the next edge
  a_r5_drop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_OWN && !hitReq) |=> (stateQ == ST_POLL));

  // R3: ownership persists while the owner keeps requesting
  a_r3_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_OWN && hitReq) |=> (stateQ == ST_OWN));

endmodule

// File: rtl/pollarb_dp.sv
module pollarb_dp
  import pollarb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic             owned,
  input  logic             rotateMode,
  output logic [IDX_W-1:0] pollIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DEV - 1);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxInc;
  logic             modeQ;

  assign idxInc = (idxQ == LAST_IDX) ? '0 : idxQ + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ <= '0;
    end else if (strobe.stepIdx) begin
      idxQ <= idxInc;
    end else if (strobe.freeBus) begin
      idxQ <= modeQ ? idxInc : '0;
    end
  end

  // restart policy is captured only while the bus is free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      modeQ <= 1'b0;
    else if (!owned) modeQ <= rotateMode;
  end

  assign pollIdx = idxQ;

  // R2: one step per polling cycle with wraparound
  a_r2_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepIdx |=> (($past(idxQ) == LAST_IDX) ? (idxQ == '0)
                                                  : (idxQ == $past(idxQ) + IDX_W'(1))));

  // R5: fixed policy restarts at zero
  a_r5_fixed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.freeBus && !modeQ) |=> (idxQ == '0));

  // R9: the policy latch is frozen while the bus is owned
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    owned |=> $stable(modeQ));

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter
  import pollarb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rotateMode,
  input  logic [NUM_DEV-1:0] devReq,
  output logic               reqLine,
  output logic [IDX_W-1:0]   pollIdx,
  output logic               busBusy,
  output logic [NUM_DEV-1:0] busGrant
);

  ctlStrobe_t strobe;
  logic       owned;
  logic       anyReq;
  logic       hitReq;

  pollarb_match #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) match_i (
    .devReq  (devReq),
    .pollIdx (pollIdx),
    .owned   (owned),
    .anyReq  (anyReq),
    .hitReq  (hitReq),
    .grantVec(busGrant)
  );

  pollarb_ctrl ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .anyReq(anyReq),
    .hitReq(hitReq),
    .strobe(strobe),
    .owned (owned)
  );

  pollarb_dp #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .owned     (owned),
    .rotateMode(rotateMode),
    .pollIdx   (pollIdx)
  );

  assign reqLine = anyReq;
  assign busBusy = owned;

  // R4: a single drive enable at most
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busGrant));

  // R4: no enable without ownership
  a_r4_grant_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|busGrant) |-> busBusy);

  // R3: a requesting addressed device takes the bus and freezes the index
  a_r3_seize: assert property (@(posedge clk) disable iff (!rst_n)
    (!busBusy && devReq[pollIdx]) |=> (busBusy && $stable(pollIdx)));

  // R8: idle with no requests holds the index and grants nothing
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busBusy && !(|devReq)) |=> ($stable(pollIdx) && !busBusy));

endmodule

// File: tb/poll_arbiter_tb_top.sv
module poll_arbiter_tb_top;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rotateMode = 1'b0;
  logic [N-1:0]  devReq = '0;
  logic          reqLine;
  logic [IW-1:0] pollIdx;
  logic          busBusy;
  logic [N-1:0]  busGrant;

  int checks = 0;
  int errors = 0;
  int cycCnt = 0;

  // behavioural reference state
  int mIdx   = 0;
  bit mOwned = 0;
  bit mMode  = 0;

  always #2.5 clk = ~clk;

  poll_arbiter #(.NUM_DEV(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .rotateMode(rotateMode), .devReq(devReq),
    .reqLine(reqLine), .pollIdx(pollIdx), .busBusy(busBusy), .busGrant(busGrant)
  );

  always @(posedge clk) begin
    bit wasOwned;
    if (!rst_n) begin
      mIdx = 0; mOwned = 0; mMode = 0;
    end else begin
      wasOwned = mOwned;
      if (mOwned) begin
        if (!devReq[mIdx]) begin
          mOwned = 0;
          mIdx = mMode ? (mIdx + 1) % N : 0;
        end
      end else if (|devReq) begin
        if (devReq[mIdx]) mOwned = 1;
        else mIdx = (mIdx + 1) % N;
      end
      if (!wasOwned) mMode = rotateMode;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    int expGrant;
    @(negedge clk);
    #1;
    expGrant = mOwned ? (1 << mIdx) : 0;
    checkEq("R1 reqLine model", int'(reqLine), int'(|devReq));
    checkEq("R2 pollIdx model", int'(pollIdx), mIdx);
    checkEq("R3 busBusy model", int'(busBusy), int'(mOwned));
    checkEq("R4 busGrant model", int'(busGrant), expGrant);
  endtask

  task automatic waitBusy(output int n);
    n = 0;
    while (!busBusy && n < 64) begin
      tick();
      n++;
    end
  endtask

  function automatic int ownerOf(input logic [N-1:0] g);
    int r = -1;
    for (int i = 0; i < N; i++) if (g[i]) r = i;
    return r;
  endfunction

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cycCnt);
      finishRun();
    end
  end

  initial begin
    int n;
    int own;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    checkEq("R10 pollIdx after reset", int'(pollIdx), 0);
    checkEq("R10 busBusy after reset", int'(busBusy), 0);
    checkEq("R10 busGrant after reset", int'(busGrant), 0);
    rst_n = 1'b1;

    // R8 idle with no requests
    repeat (3) tick();
    checkEq("R8 idle pollIdx held", int'(pollIdx), 0);
    checkEq("R8 idle no grant", int'(busGrant), 0);

    // single requester in fixed mode
    devReq = 8'h20;
    waitBusy(n);
    checkEq("R2 cycles to reach device 5", n, 6);
    checkEq("R3 grant device 5", int'(busGrant), 32'h20);
    repeat (3) tick();
    checkEq("R3 pollIdx frozen while owned", int'(pollIdx), 5);
    devReq = '0;
    tick();
    checkEq("R5 busBusy drops", int'(busBusy), 0);
    checkEq("R5 fixed restart at 0", int'(pollIdx), 0);

    // R6 fixed priority with two requesters
    devReq = 8'h24;
    waitBusy(n);
    checkEq("R6 cycles to device 2", n, 3);
    checkEq("R6 lowest index wins", int'(busGrant), 32'h04);
    devReq = 8'h20;
    tick();
    checkEq("R5 fixed restart after device 2", int'(pollIdx), 0);
    waitBusy(n);
    checkEq("R6 remaining device 5 cycles", n, 6);
    checkEq("R6 remaining device 5 granted", int'(busGrant), 32'h20);
    devReq = '0;
    tick();

    // rotating mode and wraparound
    rotateMode = 1'b1;
    tick();
    devReq = 8'h80;
    waitBusy(n);
    checkEq("R2 cycles to last device", n, 8);
    checkEq("R2 last device granted", int'(busGrant), 32'h80);
    devReq = 8'h02;
    tick();
    checkEq("R2 wrap restart to 0", int'(pollIdx), 0);
    waitBusy(n);
    checkEq("R2 device 1 after wrap", int'(busGrant), 32'h02);
    devReq = '0;
    tick();
    checkEq("R5 rotating restart after owner", int'(pollIdx), 2);

    // R7 round robin with all devices requesting
    devReq = '1;
    for (int k = 0; k < N; k++) begin
      waitBusy(n);
      own = ownerOf(busGrant);
      checkEq("R7 rotating owner order", own, (2 + k) % N);
      devReq = ~(N'(1) << own);
      tick();
      devReq = '1;
    end

    // R9 mode change while owned does not apply to that release
    waitBusy(n);
    own = ownerOf(busGrant);
    checkEq("R7 owner after full round", own, 2);
    rotateMode = 1'b0;
    repeat (2) tick();
    devReq = 8'hFB;
    tick();
    checkEq("R9 old rotating mode used at release", int'(pollIdx), 3);
    waitBusy(n);
    checkEq("R9 device 3 granted", int'(busGrant), 32'h08);
    devReq = '0;
    tick();
    checkEq("R9 fixed mode taken while idle", int'(pollIdx), 0);
    repeat (2) tick();

    finishRun();
  end

endmodule